// File: doc/BRIEF.md
# External Interrupt Pend/Mask Cascader

This block gathers 24 external interrupt sources and reduces them to six request lines for a first-level interrupt controller. Each source passes through a two-stage synchronizer and a rising-edge detector. A detected edge latches a pending bit, and that bit stays set until software clears it. Software reaches two registers over a simple register bus: one latches pending events, the other masks them. A pending bit is cleared by writing a one to its position.

The effective vector is the pending bits with the masked positions removed. The four lowest sources each drive a request line of their own, and their mask bits are fixed at zero. Sources 4 to 7 share a fifth line. Sources 8 to 23 share a sixth line. All six lines are registered.

Top module: `eint_cascader`

## Requirements
- R1: A rising edge on `src[i]` sets pending bit i once. The input is synchronized through two flops before edge detection. A level held high does not set the bit again after software clears it.
- R2: A pending bit keeps its value until a clear write that has a one in that bit position.
- R3: A write to byte offset 0xA8 clears every pending bit written as 1 and leaves every bit written as 0 unchanged. A read of 0xA8 returns the pending bits in rdata[23:0].
- R4: A write to byte offset 0xA4 stores wdata[23:4] as the mask and forces mask bits 3:0 to 0. A read of 0xA4 returns the mask in rdata[23:0].
- R5: After reset, pending reads 0x000000, the mask reads 0xFFFFF0, and all six request lines are 0.
- R6: irq[3:0] equal effective bits 3:0, one line per bit, where effective = pending AND NOT mask.
- R7: irq[4] is the OR of effective bits 7:4, and irq[5] is the OR of effective bits 23:8.
- R8: If a rising edge on source i arrives in the same cycle as a clear write with bit i set, pending bit i stays 1.
- R9: The request lines are registered. They change on the clock edge after the edge that changes pending or mask.
- R10: A read of any offset other than 0xA4 or 0xA8 returns 0, and rdata[31:24] is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src | input | 24 | External interrupt sources, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| irq | output | 6 | Request lines to the first-level controller |

## Verification
Two things can hit a pending bit in the same cycle: a newly synchronized edge that sets it, and a software write that clears it. The bench raises a source that is already pending, counts the synchronizer stages, and places the clear write on exactly the edge where the detected rise is presented. The same write also clears a second pending bit that has no new event. The check expects the colliding bit to stay set and the other bit to be cleared. A second overlap is also checked: a mask write and the next request-line update. The bench samples the request lines one cycle after the write, then again one cycle later, and expects the new value only at the second sample.

// File: rtl/eint_pkg.sv
package eint_pkg;

    localparam int unsigned NSRC     = 24;
    localparam int unsigned NDIRECT  = 4;
    localparam int unsigned GRPA_TOP = 7;
    localparam int unsigned NOUT     = NDIRECT + 2;
    localparam int unsigned AW       = 8;
    localparam int unsigned DW       = 32;
    localparam int unsigned SYNC_STG = 2;

    localparam logic [AW-1:0] OFS_MASK = 8'hA4;
    localparam logic [AW-1:0] OFS_PEND = 8'hA8;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_PEND = 2'd2
    } reg_sel_e;

    function automatic reg_sel_e decode_sel(input logic [AW-1:0] a);
        if (a == OFS_MASK)      return SEL_MASK;
        else if (a == OFS_PEND) return SEL_PEND;
        else                    return SEL_NONE;
    endfunction

endpackage

// File: rtl/eint_sync_edge.sv
module eint_sync_edge #(
    parameter int unsigned N      = eint_pkg::NSRC,
    parameter int unsigned STAGES = eint_pkg::SYNC_STG
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] src,
    output logic [N-1:0] rise
);
    logic [N-1:0] stg [STAGES];
    logic [N-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= src;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[k] <= '0;
            else     stg[k] <= stg[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '0;
        else     prev <= stg[STAGES-1];
    end

    assign rise = stg[STAGES-1] & ~prev;

    // R1: a detected rise lasts one cycle per source
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((rise & $past(rise)) == '0));

endmodule

// File: rtl/eint_regs.sv
module eint_regs
    import eint_pkg::*;
#(
    parameter int unsigned N  = NSRC,
    parameter int unsigned ND = NDIRECT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  rise,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [N-1:0]  pend,
    output logic [N-1:0]  mask,
    output logic [DW-1:0] rdata
);
    localparam logic [N-1:0] LOCK     = {{(N-ND){1'b0}}, {ND{1'b1}}};
    localparam logic [N-1:0] MASK_RST = ~LOCK;

    reg_sel_e     sel;
    logic         clr_wr;
    logic         msk_wr;
    logic [N-1:0] clr_bits;

    assign sel      = decode_sel(addr);
    assign clr_wr   = wr_en && (sel == SEL_PEND);
    assign msk_wr   = wr_en && (sel == SEL_MASK);
    assign clr_bits = clr_wr ? wdata[N-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            mask <= MASK_RST;
        end else begin
            pend <= (pend & ~clr_bits) | rise;
            if (msk_wr) mask <= wdata[N-1:0] & ~LOCK;
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_MASK: rdata[N-1:0] = mask;
            SEL_PEND: rdata[N-1:0] = pend;
            default:  rdata = '0;
        endcase
    end

    // R2: with no event and no clear, pending holds
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr_wr && rise == '0) |=> $stable(pend));

    // R3: bits written as one without a new event end up cleared
    a_r3_w1c: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> ((pend & $past(wdata[N-1:0] & ~rise)) == '0));

    // R8: an event always leaves its bit set
    a_r8_event_wins: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~pend & $past(rise)) == '0));

    // R4: low mask bits stay clear after a mask write
    a_r4_lock: assert property (@(posedge clk) disable iff (rst)
        msk_wr |=> (mask[ND-1:0] == '0));

endmodule

// File: rtl/eint_cascade.sv
module eint_cascade
    import eint_pkg::*;
#(
    parameter int unsigned N   = NSRC,
    parameter int unsigned ND  = NDIRECT,
    parameter int unsigned GAT = GRPA_TOP,
    parameter int unsigned NO  = ND + 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  pend,
    input  logic [N-1:0]  mask,
    output logic [NO-1:0] irq
);
    logic [N-1:0]  eff;
    logic [NO-1:0] nxt;

    assign eff = pend & ~mask;

    for (genvar d = 0; d < ND; d++) begin : g_direct
        assign nxt[d] = eff[d];
    end
    assign nxt[ND]   = |eff[GAT:ND];
    assign nxt[ND+1] = |eff[N-1:GAT+1];

    always_ff @(posedge clk) begin
        if (rst) irq <= '0;
        else     irq <= nxt;
    end

    // R6: direct lines track pending a cycle later whatever was written to mask
    a_r6_direct: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq[ND-1:0] == $past(pend[ND-1:0])));

    // R7: upper group line is quiet when none of its sources is pending
    a_r7_grp_quiet: assert property (@(posedge clk) disable iff (rst)
        (pend[N-1:GAT+1] == '0) |=> !irq[ND+1]);

endmodule

// File: rtl/eint_cascader.sv
module eint_cascader
    import eint_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    output logic [NOUT-1:0] irq
);
    logic [NSRC-1:0] rise;
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] mask;

    eint_sync_edge #(.N(NSRC), .STAGES(SYNC_STG)) u_sync (
        .clk (clk),
        .rst (rst),
        .src (src),
        .rise(rise)
    );

    eint_regs #(.N(NSRC), .ND(NDIRECT)) u_regs (
        .clk  (clk),
        .rst  (rst),
        .rise (rise),
        .wr_en(wr_en),
        .addr (addr),
        .wdata(wdata),
        .pend (pend),
        .mask (mask),
        .rdata(rdata)
    );

    eint_cascade #(.N(NSRC), .ND(NDIRECT), .GAT(GRPA_TOP), .NO(NOUT)) u_casc (
        .clk (clk),
        .rst (rst),
        .pend(pend),
        .mask(mask),
        .irq (irq)
    );

    // R5: request lines are low in the cycle after reset
    a_r5_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (irq == '0));

endmodule

// File: tb/test_eint_cascader.sv
module test_eint_cascader;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] src = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [5:0]  irq;

    int total = 0;
    int bad   = 0;

    localparam logic [7:0] A_MASK = 8'hA4;
    localparam logic [7:0] A_PEND = 8'hA8;

    always #5 clk = ~clk;

    eint_cascader i_eint_cascader (
        .clk(clk), .rst(rst), .src(src), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    function automatic logic [5:0] exp_irq(input logic [23:0] p, input logic [23:0] m);
        logic [23:0] e;
        e = p & ~m;
        return {|e[23:8], |e[7:4], e[3:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic pulse(input logic [23:0] v);
        @(negedge clk);
        src = v;
        @(negedge clk);
        src = '0;
        cyc(5);
    endtask

    initial begin
        #(200000 * 10);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [23:0] ep;
        logic [23:0] em;

        cyc(3);
        rst = 1'b0;
        @(negedge clk);
        // R5 reset values
        rd(A_PEND, d); chk("R5 pend", d, 32'h0);
        rd(A_MASK, d); chk("R5 mask", d, 32'h00FF_FFF0);
        chk("R5 irq", {26'd0, irq}, 32'h0);

        // R10 other offsets and upper bits
        rd(8'h00, d); chk("R10 unused", d, 32'h0);
        rd(8'hA0, d); chk("R10 unused", d, 32'h0);

        // R4: unmask all, low bits remain zero
        wr(A_MASK, 32'hFFFF_FFFF);
        rd(A_MASK, d); chk("R4 mask lock", d, 32'h00FF_FFF0);
        wr(A_MASK, 32'h0);
        em = '0;

        // sweep: R1, R3, R6, R7
        for (int i = 0; i < 24; i++) begin
            ep = 24'(1) << i;
            pulse(ep);
            rd(A_PEND, d); chk("R1 set", d, {8'd0, ep});
            chk("R6/R7 irq", {26'd0, irq}, {26'd0, exp_irq(ep, em)});
            wr(A_PEND, {8'hFF, ep});
            cyc(1);
            rd(A_PEND, d); chk("R3 cleared", d, 32'h0);
            chk("R6/R7 irq off", {26'd0, irq}, 32'h0);
        end

        // R2/R6: all sources with reset-style mask
        wr(A_MASK, 32'h00FF_FFF0);
        em = 24'hFFFFF0;
        pulse(24'hFF_FFFF);
        ep = 24'hFF_FFFF;
        rd(A_PEND, d); chk("R2 all pending", d, {8'd0, ep});
        chk("R6 masked", {26'd0, irq}, {26'd0, exp_irq(ep, em)});
        cyc(10);
        rd(A_PEND, d); chk("R2 held", d, {8'd0, ep});

        // R7: open bit 5 only
        wr(A_MASK, ~32'h20);
        em = 24'hFFFFD0;
        cyc(1);
        chk("R7 group a", {26'd0, irq}, {26'd0, exp_irq(ep, em)});
        // R3: zeros leave bits alone
        wr(A_PEND, 32'h0000_00F0);
        ep = ep & ~24'hF0;
        rd(A_PEND, d); chk("R3 partial", d, {8'd0, ep});

        // R9: mask change reaches irq one edge later
        wr(A_PEND, 32'h00FF_FFFF);
        ep = '0;
        pulse(24'h00_0400);
        ep = 24'h00_0400;
        chk("R9 pre", {26'd0, irq}, {26'd0, exp_irq(ep, em)});
        @(negedge clk);
        wr_en = 1'b1; addr = A_MASK; wdata = 32'h0;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R9 not yet", {26'd0, irq}, 32'h0);
        em = '0;
        @(negedge clk);
        chk("R9 updated", {26'd0, irq}, {26'd0, exp_irq(ep, em)});

        // R8: event and clear in the same cycle
        wr(A_PEND, 32'h00FF_FFFF);
        pulse(24'h00_0204);
        @(negedge clk);
        src = 24'h00_0004;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b1; addr = A_PEND; wdata = 32'h0000_0204;
        @(negedge clk);
        wr_en = 1'b0; src = '0;
        rd(A_PEND, d); chk("R8 event wins", d, 32'h0000_0004);

        // R1: held level does not retrigger
        wr(A_PEND, 32'h00FF_FFFF);
        @(negedge clk);
        src = 24'h00_8000;
        cyc(6);
        wr(A_PEND, 32'h0000_8000);
        cyc(6);
        rd(A_PEND, d); chk("R1 level once", d, 32'h0);
        src = '0;
        cyc(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule